// File: doc/BRIEF.md
# Registered Three-Port Bus Exchanger

This block joins one host-side data port (A) to two memory-side data ports, one serving the even bank (1B) and one serving the odd bank (1B's partner, 2B). It is meant for interleaved memory access. Four independent storage registers carry data, one per direction and path: A toward 1B, A toward 2B, 1B toward A and 2B toward A. A path select chooses which of the two return registers drives port A.

The path select and the two drive enables pass through a control register. As a result, a change of direction or of return path always lands on a rising clock edge.

Each bidirectional port is split into an input, an output and a drive flag. Every port has a keeper. When the block is not driving a port, the keeper holds the value last seen on that line. The value on a line is the block's own output when the block drives it, and the external input otherwise. The registers always load from this line value.

Top module: `tri_port_exchanger`

## Requirements
- R1: With `rst` high at a rising edge, the next state has all four data registers at zero, the select on the odd (2B) path and both drive flags low. All three outputs read zero until new data arrives.
- R2: The A-to-even register loads the A line value at a rising edge where `ld_a_even_n` is 0. It keeps its value indefinitely while that enable is 1.
- R3: The A-to-odd register behaves the same way under `ld_a_odd_n`. If both A-side enables are 0 on one edge, both registers capture the same A line value.
- R4: The even-to-A and odd-to-A registers load the 1B and 2B line values at an edge where `ld_even_a_n` or `ld_odd_a_n`, respectively, is 0. Each keeps its value while its enable is 1.
- R5: `path_even` is sampled at the rising edge. When the sample is 1, A is driven from the even-to-A register. When it is 0, A is driven from the odd-to-A register. The new choice shows from that edge on.
- R6: `a_oe` equals the inverse of `drv_a_n` sampled at the previous rising edge. While `a_oe` is 1, `a_out` shows the selected return register.
- R7: `b_even_oe` and `b_odd_oe` are always equal. Each equals the inverse of `drv_b_n` sampled at the previous edge. While they are 1, `b_even_out` shows the A-to-even register and `b_odd_out` shows the A-to-odd register.
- R8: While a port's drive flag is 0, its output equals that port's line value at the previous edge. The line value is the port's own driven value if the port was driving, and its external input otherwise.
- R9: A register that loads from a port the block is currently driving captures the block's own driven value, not the external input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock shared by every register |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | 12 | External value on port A |
| a_out | output | 12 | Value the block places on port A (held value when not driving) |
| a_oe | output | 1 | Block drives port A |
| b_even_in | input | 12 | External value on even-bank port 1B |
| b_even_out | output | 12 | Value on port 1B from the block or its keeper |
| b_even_oe | output | 1 | Block drives port 1B |
| b_odd_in | input | 12 | External value on odd-bank port 2B |
| b_odd_out | output | 12 | Value on port 2B from the block or its keeper |
| b_odd_oe | output | 1 | Block drives port 2B |
| ld_a_even_n | input | 1 | Load A-to-even register, active low |
| ld_a_odd_n | input | 1 | Load A-to-odd register, active low |
| ld_even_a_n | input | 1 | Load even-to-A register, active low |
| ld_odd_a_n | input | 1 | Load odd-to-A register, active low |
| path_even | input | 1 | Return path select: 1 picks even, 0 picks odd |
| drv_a_n | input | 1 | Drive request for port A, active low, registered |
| drv_b_n | input | 1 | Drive request for both B ports, active low, registered |

## Verification
The bench first loads the even and odd banks on alternate cycles with distinct values. This separates the two A-side registers and shows that an idle enable really holds its register. It then fills both return registers with different words and flips the select. The A output must change exactly at the edge that latched the new select, which tells a registered select from a combinational one. Turnaround sequences swap drive between A and the B ports, both while external values change and while the block loads its own driven lines. This separates the keeper's value from the external input and a loopback load from an external load.

// File: rtl/xchg_pkg.sv
package xchg_pkg;

  typedef struct packed {
    logic sel_even;
    logic a_drive;
    logic b_drive;
  } xchg_ctrl_t;

  localparam int NUM_B_PATHS = 2;
  localparam int PATH_EVEN   = 0;
  localparam int PATH_ODD    = 1;

endpackage

// File: rtl/xchg_ctrl_reg.sv
module xchg_ctrl_reg
  import xchg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       path_even,
  input  logic       drv_a_n,
  input  logic       drv_b_n,
  output xchg_ctrl_t ctrl_q
);

  function automatic xchg_ctrl_t decode_ctrl(input logic sel, input logic da_n,
                                             input logic db_n);
    xchg_ctrl_t c;
    c.sel_even = sel;
    c.a_drive  = ~da_n;
    c.b_drive  = ~db_n;
    return c;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else begin
      ctrl_q <= decode_ctrl(path_even, drv_a_n, drv_b_n);
    end
  end

endmodule

// File: rtl/xchg_hold_reg.sv
module xchg_hold_reg #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (!load_n) begin
      q <= d;
    end
  end

endmodule

// File: rtl/xchg_port_keeper.sv
module xchg_port_keeper #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         drive,
  input  logic [W-1:0] drv_val,
  input  logic [W-1:0] ext_in,
  output logic [W-1:0] line,
  output logic [W-1:0] out_val
);

  logic [W-1:0] keep_q;

  function automatic logic [W-1:0] resolve(input logic drv, input logic [W-1:0] own,
                                           input logic [W-1:0] ext);
    return drv ? own : ext;
  endfunction

  assign line    = resolve(drive, drv_val, ext_in);
  assign out_val = resolve(drive, drv_val, keep_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      keep_q <= '0;
    end else begin
      keep_q <= line;
    end
  end

endmodule

// File: rtl/tri_port_exchanger.sv
module tri_port_exchanger
  import xchg_pkg::*;
#(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  input  logic [W-1:0] b_even_in,
  output logic [W-1:0] b_even_out,
  output logic         b_even_oe,
  input  logic [W-1:0] b_odd_in,
  output logic [W-1:0] b_odd_out,
  output logic         b_odd_oe,
  input  logic         ld_a_even_n,
  input  logic         ld_a_odd_n,
  input  logic         ld_even_a_n,
  input  logic         ld_odd_a_n,
  input  logic         path_even,
  input  logic         drv_a_n,
  input  logic         drv_b_n
);

  localparam int NP = NUM_B_PATHS;

  xchg_ctrl_t   ctrl_q;
  logic [W-1:0] a_line;
  logic [W-1:0] a_drv_val;
  logic [W-1:0] q_a2b  [NP];
  logic [W-1:0] q_b2a  [NP];
  logic [W-1:0] b_in_v [NP];
  logic [W-1:0] b_line [NP];
  logic [W-1:0] b_out_v[NP];
  logic         ld_a2b_n[NP];
  logic         ld_b2a_n[NP];

  function automatic logic [W-1:0] pick_return(input logic sel_even,
                                               input logic [W-1:0] even_v,
                                               input logic [W-1:0] odd_v);
    return sel_even ? even_v : odd_v;
  endfunction

  assign b_in_v[PATH_EVEN]   = b_even_in;
  assign b_in_v[PATH_ODD]    = b_odd_in;
  assign ld_a2b_n[PATH_EVEN] = ld_a_even_n;
  assign ld_a2b_n[PATH_ODD]  = ld_a_odd_n;
  assign ld_b2a_n[PATH_EVEN] = ld_even_a_n;
  assign ld_b2a_n[PATH_ODD]  = ld_odd_a_n;

  xchg_ctrl_reg u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .path_even (path_even),
    .drv_a_n   (drv_a_n),
    .drv_b_n   (drv_b_n),
    .ctrl_q    (ctrl_q)
  );

  assign a_drv_val = pick_return(ctrl_q.sel_even, q_b2a[PATH_EVEN], q_b2a[PATH_ODD]);

  xchg_port_keeper #(.W(W)) u_keep_a (
    .clk     (clk),
    .rst     (rst),
    .drive   (ctrl_q.a_drive),
    .drv_val (a_drv_val),
    .ext_in  (a_in),
    .line    (a_line),
    .out_val (a_out)
  );

  assign a_oe = ctrl_q.a_drive;

  for (genvar g = 0; g < NP; g++) begin : g_path
    xchg_hold_reg #(.W(W)) u_a2b (
      .clk    (clk),
      .rst    (rst),
      .load_n (ld_a2b_n[g]),
      .d      (a_line),
      .q      (q_a2b[g])
    );

    xchg_port_keeper #(.W(W)) u_keep_b (
      .clk     (clk),
      .rst     (rst),
      .drive   (ctrl_q.b_drive),
      .drv_val (q_a2b[g]),
      .ext_in  (b_in_v[g]),
      .line    (b_line[g]),
      .out_val (b_out_v[g])
    );

    xchg_hold_reg #(.W(W)) u_b2a (
      .clk    (clk),
      .rst    (rst),
      .load_n (ld_b2a_n[g]),
      .d      (b_line[g]),
      .q      (q_b2a[g])
    );
  end

  assign b_even_out = b_out_v[PATH_EVEN];
  assign b_odd_out  = b_out_v[PATH_ODD];
  assign b_even_oe  = ctrl_q.b_drive;
  assign b_odd_oe   = ctrl_q.b_drive;

endmodule

// File: rtl/xchg_checker.sv
module xchg_checker #(
  parameter int W = 12
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] a_in,
  input logic [W-1:0] a_out,
  input logic         a_oe,
  input logic [W-1:0] b_even_in,
  input logic [W-1:0] b_even_out,
  input logic         b_even_oe,
  input logic [W-1:0] b_odd_in,
  input logic [W-1:0] b_odd_out,
  input logic         b_odd_oe,
  input logic         ld_a_even_n,
  input logic         ld_a_odd_n,
  input logic         ld_even_a_n,
  input logic         ld_odd_a_n,
  input logic         path_even,
  input logic         drv_a_n,
  input logic         drv_b_n
);

  logic seen_edge;
  always_ff @(posedge clk) seen_edge <= 1'b1;

  a_r1_reset_quiet: assert property (@(posedge clk)
    seen_edge && $past(rst) |-> !a_oe && !b_even_oe && a_out == '0 && b_odd_out == '0);

  a_r6_a_oe_registered: assert property (@(posedge clk) disable iff (rst)
    seen_edge && !$past(rst) |-> a_oe == !$past(drv_a_n));

  a_r7_b_oe_shared: assert property (@(posedge clk) disable iff (rst)
    b_even_oe == b_odd_oe);

  a_r2_even_holds: assert property (@(posedge clk) disable iff (rst)
    seen_edge && !$past(rst) && $past(ld_a_even_n) && $past(b_even_oe) && b_even_oe
    |-> $stable(b_even_out));

  a_r5_even_return: assert property (@(posedge clk) disable iff (rst)
    seen_edge && !$past(rst) && a_oe && $past(path_even) && !$past(b_even_oe)
    && !$past(ld_even_a_n) |-> a_out == $past(b_even_in));

  a_r8_a_keeper: assert property (@(posedge clk) disable iff (rst)
    seen_edge && !$past(rst) && !a_oe |-> a_out == ($past(a_oe) ? $past(a_out) : $past(a_in)));

endmodule

bind tri_port_exchanger xchg_checker #(.W(W)) u_chk (.*);

// File: tb/tb_tri_port_exchanger.sv
`timescale 1ns/1ps
module tb_tri_port_exchanger;
  localparam int W = 12;

  logic clk = 1'b0;
  logic rst;
  logic [W-1:0] a_in, b_even_in, b_odd_in;
  logic [W-1:0] a_out, b_even_out, b_odd_out;
  logic a_oe, b_even_oe, b_odd_oe;
  logic ld_a_even_n, ld_a_odd_n, ld_even_a_n, ld_odd_a_n;
  logic path_even, drv_a_n, drv_b_n;

  int checks = 0;
  int errors = 0;

  // reference state
  logic [W-1:0] m_ae, m_ao, m_ea, m_oa, m_ka, m_ke, m_ko;
  logic m_sel, m_adrv, m_bdrv;

  always #5 clk = ~clk;

  tri_port_exchanger #(.W(W)) dut (.*);

  task automatic chk(input string tag, input string what, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [W-1:0] exp_a();
    logic [W-1:0] ret;
    ret = m_sel ? m_ea : m_oa;
    return m_adrv ? ret : m_ka;
  endfunction

  task automatic compare(input string tag);
    chk(tag, "a_out", a_out, exp_a());
    chk(tag, "a_oe", {{(W-1){1'b0}}, a_oe}, {{(W-1){1'b0}}, m_adrv});
    chk(tag, "b_even_out", b_even_out, m_bdrv ? m_ae : m_ke);
    chk(tag, "b_odd_out", b_odd_out, m_bdrv ? m_ao : m_ko);
    chk(tag, "b_even_oe", {{(W-1){1'b0}}, b_even_oe}, {{(W-1){1'b0}}, m_bdrv});
    chk(tag, "b_odd_oe", {{(W-1){1'b0}}, b_odd_oe}, {{(W-1){1'b0}}, m_bdrv});
  endtask

  // one clock: model update from inputs present at the edge, then compare
  task automatic step(input string tag);
    logic [W-1:0] la, le, lo;
    @(posedge clk);
    la = m_adrv ? (m_sel ? m_ea : m_oa) : a_in;
    le = m_bdrv ? m_ae : b_even_in;
    lo = m_bdrv ? m_ao : b_odd_in;
    if (rst) begin
      m_ae = '0; m_ao = '0; m_ea = '0; m_oa = '0;
      m_ka = '0; m_ke = '0; m_ko = '0;
      m_sel = 1'b0; m_adrv = 1'b0; m_bdrv = 1'b0;
    end else begin
      if (!ld_a_even_n) m_ae = la;
      if (!ld_a_odd_n)  m_ao = la;
      if (!ld_even_a_n) m_ea = le;
      if (!ld_odd_a_n)  m_oa = lo;
      m_ka = la; m_ke = le; m_ko = lo;
      m_sel = path_even; m_adrv = ~drv_a_n; m_bdrv = ~drv_b_n;
    end
    #2;
    compare(tag);
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    ld_a_even_n = 1'b1; ld_a_odd_n = 1'b1; ld_even_a_n = 1'b1; ld_odd_a_n = 1'b1;
  endtask

  task automatic t_reset();
    rst = 1'b1; idle_inputs(); path_even = 1'b1; drv_a_n = 1'b0; drv_b_n = 1'b0;
    a_in = 12'hABC; b_even_in = 12'h123; b_odd_in = 12'h456;
    step("R1"); step("R1");
    rst = 1'b0; path_even = 1'b0; drv_a_n = 1'b1; drv_b_n = 1'b1;
    step("R1");
  endtask

  // alternate even/odd loads from A, then drive B ports to observe
  task automatic t_even_odd();
    for (int i = 0; i < 6; i++) begin
      idle_inputs();
      a_in = 12'h100 + 12'(i * 37);
      if (i % 2 == 0) ld_a_even_n = 1'b0; else ld_a_odd_n = 1'b0;
      drv_b_n = (i > 2) ? 1'b0 : 1'b1;
      step("R2/R3/R7");
    end
    idle_inputs(); a_in = 12'h5A5; ld_a_even_n = 1'b0; ld_a_odd_n = 1'b0;
    step("R3");
    idle_inputs(); a_in = 12'hFFF;
    step("R2"); step("R2");
  endtask

  // load return registers from outside, select toggles, A drive
  task automatic t_return_sel();
    drv_b_n = 1'b1; idle_inputs();
    step("R8");
    b_even_in = 12'h0E1; b_odd_in = 12'h0D2; ld_even_a_n = 1'b0; ld_odd_a_n = 1'b0;
    step("R4");
    idle_inputs(); b_even_in = 12'h777; b_odd_in = 12'h888;
    drv_a_n = 1'b0; path_even = 1'b1;
    step("R4/R6");
    for (int i = 0; i < 5; i++) begin
      path_even = ~path_even;
      if (i == 2) ld_odd_a_n = 1'b0; else ld_odd_a_n = 1'b1;
      b_odd_in = 12'h300 + 12'(i);
      step("R5");
    end
    idle_inputs();
  endtask

  // direction turnaround with loopback loads and keeper observation
  task automatic t_turnaround();
    for (int i = 0; i < 8; i++) begin
      idle_inputs();
      a_in = 12'hC00 + 12'(i * 11);
      b_even_in = 12'h0A0 + 12'(i);
      b_odd_in = 12'h0B0 + 12'(i);
      drv_a_n = i[0];
      drv_b_n = ~i[0];
      path_even = i[1];
      ld_a_even_n = i[1];
      ld_a_odd_n = ~i[1];
      ld_even_a_n = ~i[2];
      ld_odd_a_n = i[2];
      step("R6/R8/R9");
    end
    idle_inputs(); drv_a_n = 1'b1; drv_b_n = 1'b1; a_in = 12'h321;
    step("R8"); step("R8");
    // loopback: A driving, A-side register loads the driven value (R9)
    drv_a_n = 1'b0; path_even = 1'b0;
    step("R9");
    ld_a_odd_n = 1'b0; a_in = 12'h999;
    step("R9");
    idle_inputs(); drv_b_n = 1'b0;
    step("R9"); step("R9");
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst = 1'b1; idle_inputs(); path_even = 1'b0; drv_a_n = 1'b1; drv_b_n = 1'b1;
    a_in = '0; b_even_in = '0; b_odd_in = '0;
    m_ae = '0; m_ao = '0; m_ea = '0; m_oa = '0; m_ka = '0; m_ke = '0; m_ko = '0;
    m_sel = 1'b0; m_adrv = 1'b0; m_bdrv = 1'b0;
    @(negedge clk);
    t_reset();
    t_even_odd();
    t_return_sel();
    t_turnaround();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule